// File: doc/BRIEF.md
# Telecom Line-Test Bit Pattern Generator

This block emits a serial test bit stream for checking a transmission line. One code picks the pattern: a fixed repeating word (all zeros, all ones, alternating, 1-in-8, 2-in-8, 3-in-24) or a pseudo-random sequence from a linear feedback shift register (a 9-stage and an 11-stage maximal-length sequence, and a 20-stage sequence with a zero-run limit). A downstream serializer pulses `bit_en` once for each bit it wants. The block answers one cycle later with `tx_valid` high and the bit on `tx_bit`.

The select code is taken only when `restart` is pulsed. A restart also sends the pattern back to its first bit and seeds every shift register with all ones. A one-cycle `err_inject` pulse inverts exactly one later output bit, so the far end can prove that its error counter works.

A controller with four states runs the block. **IDLE** is entered at reset, and on any restart with an unused code; no bits come out in this state. **FIXED** is entered on a restart with codes 0 to 5. **PRBS** is entered on a restart with codes 6 or 7. **QRSS** is entered on a restart with code 8. Every state moves on a restart, and only on a restart, to the state that the sampled code selects. Without a restart the state holds.

Top module: `bert_patgen`

## Requirements
- R1: After reset `tx_valid` is 0 and the block is in IDLE. `bit_en` produces no valid bit until a restart with a used code.
- R2: `pat_sel` is sampled only in a cycle with `restart` high. Changing it at any other time does not change the output stream.
- R3: In FIXED, PRBS or QRSS, a cycle with `bit_en` high and `restart` low makes `tx_valid` high in the next cycle with the next pattern bit. Otherwise `tx_valid` is low in the next cycle. Gaps in `bit_en` pause the sequence without skipping bits.
- R4: Code 0 gives constant 0 and code 1 gives constant 1. Code 2 alternates 1,0,1,0... starting with 1. Code 3 repeats a 1 followed by seven 0s.
- R5: Code 4 repeats the 8-bit word 0,1,0,0,0,0,1,0 (first bit first), so it never has more than four zeros in a row.
- R6: Code 5 repeats the 24-bit word with ones only at positions 1, 5 and 21 (position 0 first), which is three ones in 24 bits (12.5 percent).
- R7: Code 6 runs a 9-stage register seeded all ones. The output is stage 9. Each step shifts every stage up by one and loads stage 1 with stage 9 XOR stage 5. The output repeats every 511 bits and has 256 ones per period.
- R8: Code 7 behaves like R7 with 11 stages and feedback from stages 11 and 9. The period is 2047.
- R9: Code 8 runs a 20-stage register with feedback from stages 20 and 17. The output is forced to 1 when 13 zeros in a row have just been emitted, so 14 zeros in a row never appear. Forcing does not alter the register.
- R10: A restart with a code from 9 to 15 enters IDLE, and no valid bit is produced.
- R11: An `err_inject` pulse inverts the next valid bit. If the pulse comes in a cycle with `bit_en`, it inverts that cycle's bit. Later bits are unaffected, and the pattern sequence continues as if nothing had been inserted.
- R12: A restart returns the pattern to its first bit, discards a pending error, and gives no valid bit in the following cycle.
- R13: No shift register ever holds all zeros, so the 11-stage output never has more than 10 zeros in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Request for one output bit |
| pat_sel | input | 4 | Pattern code, sampled on restart |
| restart | input | 1 | Load code and restart pattern |
| err_inject | input | 1 | One-shot request to invert one bit |
| tx_bit | output | 1 | Serial pattern bit, meaningful with tx_valid |
| tx_valid | output | 1 | tx_bit carries a new bit this cycle |

## Verification
The hardest behaviour to reach from the ports is the zero-run clamp of the 20-stage sequence. It only acts after a long run of zeros, and such runs come a few dozen times in a million bits. The stimulus therefore streams 100000 QRSS bits without a gap. Every bit is compared against an independent model of the register and the clamp, and the longest zero run actually seen is tracked. Error insertion is reached in two ways: a pulse during a pause in `bit_en`, so the error has to wait, and a pulse in the same cycle as a request. A third case puts a restart between the pulse and the next bit, which must discard the error.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam logic [3:0] PAT_ZEROS  = 4'd0;
    localparam logic [3:0] PAT_ONES   = 4'd1;
    localparam logic [3:0] PAT_ALT    = 4'd2;
    localparam logic [3:0] PAT_1IN8   = 4'd3;
    localparam logic [3:0] PAT_2IN8   = 4'd4;
    localparam logic [3:0] PAT_3IN24  = 4'd5;
    localparam logic [3:0] PAT_PRBS9  = 4'd6;
    localparam logic [3:0] PAT_PRBS11 = 4'd7;
    localparam logic [3:0] PAT_QRSS   = 4'd8;

    // words are sent most significant bit first
    localparam logic [7:0]  WORD_2IN8  = 8'b0100_0010;
    localparam logic [23:0] WORD_3IN24 = 24'b0100_0100_0000_0000_0000_0100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIXED,
        ST_PRBS,
        ST_QRSS
    } gen_state_e;

endpackage

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
    parameter int W   = 9,
    parameter int TAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic out_bit
);

    logic [W-1:0] s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else if (load) begin
            s_q <= '1;
        end else if (step) begin
            s_q <= {s_q[W-2:0], s_q[W-1] ^ s_q[TAP-1]};
        end
    end

    assign out_bit = s_q[W-1];

    // R13: the register never falls into the all-zero state
    a_r13_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        s_q != '0);

endmodule

// File: rtl/bert_static.sv
module bert_static
    import bert_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       step,
    input  logic [3:0] mode,
    output logic       bit_o
);

    logic [4:0] idx_q;
    logic [4:0] last_idx;

    always_comb begin
        case (mode)
            PAT_ALT:            last_idx = 5'd1;
            PAT_1IN8, PAT_2IN8: last_idx = 5'd7;
            PAT_3IN24:          last_idx = 5'd23;
            default:            last_idx = 5'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q >= last_idx) ? 5'd0 : 5'(idx_q + 5'd1);
        end
    end

    always_comb begin
        case (mode)
            PAT_ONES:  bit_o = 1'b1;
            PAT_ALT:   bit_o = ~idx_q[0];
            PAT_1IN8:  bit_o = (idx_q == 5'd0);
            PAT_2IN8:  bit_o = WORD_2IN8[3'd7 - idx_q[2:0]];
            PAT_3IN24: bit_o = WORD_3IN24[5'd23 - idx_q];
            default:   bit_o = 1'b0;
        endcase
    end

    // R6: the position counter stays inside the longest word
    a_r6_idx_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= 5'd23);

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
#(
    parameter int PRBS_A_W   = 9,
    parameter int PRBS_A_TAP = 5,
    parameter int PRBS_B_W   = 11,
    parameter int PRBS_B_TAP = 9,
    parameter int QRSS_W     = 20,
    parameter int QRSS_TAP   = 17,
    parameter int QRSS_MAX_ZEROS = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [3:0] pat_sel,
    input  logic       restart,
    input  logic       err_inject,
    output logic       tx_bit,
    output logic       tx_valid
);

    localparam int NL   = 3;
    localparam int ZR_W = $clog2(QRSS_MAX_ZEROS + 1);
    localparam int LW [NL] = '{PRBS_A_W, PRBS_B_W, QRSS_W};
    localparam int LT [NL] = '{PRBS_A_TAP, PRBS_B_TAP, QRSS_TAP};

    gen_state_e      state_q, state_d;
    logic [3:0]      mode_q;
    logic            run_step;
    logic            static_bit;
    logic [NL-1:0]   lfsr_bit;
    logic            pat_bit;
    logic [ZR_W-1:0] zrun_q;
    logic            err_pend;
    logic            tx_err_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            case (pat_sel)
                PAT_ZEROS, PAT_ONES, PAT_ALT,
                PAT_1IN8, PAT_2IN8, PAT_3IN24: state_d = ST_FIXED;
                PAT_PRBS9, PAT_PRBS11:         state_d = ST_PRBS;
                PAT_QRSS:                      state_d = ST_QRSS;
                default:                       state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= PAT_ZEROS;
        end else begin
            state_q <= state_d;
            if (restart) mode_q <= pat_sel;
        end
    end

    assign run_step = bit_en && !restart && (state_q != ST_IDLE);

    bert_static u_static (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (restart),
        .step  (run_step),
        .mode  (mode_q),
        .bit_o (static_bit)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lfsr
        bert_lfsr #(.W(LW[g]), .TAP(LT[g])) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (restart),
            .step    (run_step),
            .out_bit (lfsr_bit[g])
        );
    end

    // pattern bit selection
    always_comb begin
        unique case (state_q)
            ST_IDLE:  pat_bit = 1'b0;
            ST_FIXED: pat_bit = static_bit;
            ST_PRBS:  pat_bit = (mode_q == PAT_PRBS11) ? lfsr_bit[1] : lfsr_bit[0];
            ST_QRSS:  pat_bit = lfsr_bit[2] | (zrun_q == ZR_W'(QRSS_MAX_ZEROS - 1));
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (restart) begin
            zrun_q <= '0;
        end else if (run_step && state_q == ST_QRSS) begin
            zrun_q <= pat_bit ? '0 : ZR_W'(zrun_q + 1'b1);
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_bit   <= 1'b0;
            tx_err_q <= 1'b0;
            err_pend <= 1'b0;
        end else if (restart) begin
            tx_valid <= 1'b0;
            tx_err_q <= 1'b0;
            err_pend <= 1'b0;
        end else if (run_step) begin
            tx_valid <= 1'b1;
            tx_bit   <= pat_bit ^ (err_pend | err_inject);
            tx_err_q <= err_pend | err_inject;
            err_pend <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            if (err_inject) err_pend <= 1'b1;
        end
    end

    // checker: zero run of the clean QRSS output stream
    logic [ZR_W:0] qz_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qz_q <= '0;
        end else if (restart) begin
            qz_q <= '0;
        end else if (tx_valid && mode_q == PAT_QRSS) begin
            if (tx_bit ^ tx_err_q)                       qz_q <= '0;
            else if (qz_q != (ZR_W+1)'(QRSS_MAX_ZEROS)) qz_q <= (ZR_W+1)'(qz_q + 1'b1);
        end
    end

    a_r9_qrss_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        qz_q < (ZR_W+1)'(QRSS_MAX_ZEROS));

    a_r3_valid_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(bit_en) && !$past(restart)));

    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !tx_valid);

    a_r12_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tx_valid && !err_pend));

    a_r11_err_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !err_pend);

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(mode_q));

endmodule

// File: tb/sim_bert_patgen.sv
`timescale 1ns/1ps
module sim_bert_patgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] pat_sel = 4'd0;
    logic       restart = 1'b0;
    logic       err_inject = 1'b0;
    logic       tx_bit;
    logic       tx_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bert_patgen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .pat_sel    (pat_sel),
        .restart    (restart),
        .err_inject (err_inject),
        .tx_bit     (tx_bit),
        .tx_valid   (tx_valid)
    );

    // ---------------- reference model ----------------
    logic [19:0] m_s;
    int m_w, m_t, m_idx, m_z;
    logic [3:0] m_code;

    task automatic m_init(input logic [3:0] code);
        m_code = code; m_s = '1; m_idx = 0; m_z = 0;
        m_w = (code == 4'd6) ? 9 : (code == 4'd7) ? 11 : 20;
        m_t = (code == 4'd6) ? 5 : (code == 4'd7) ? 9 : 17;
    endtask

    task automatic m_next(output logic b);
        logic raw;
        case (m_code)
            4'd0: b = 1'b0;
            4'd1: b = 1'b1;
            4'd2: b = (m_idx % 2 == 0);
            4'd3: b = (m_idx % 8 == 0);
            4'd4: b = (m_idx % 8 == 1) || (m_idx % 8 == 6);
            4'd5: b = (m_idx % 24 == 1) || (m_idx % 24 == 5) || (m_idx % 24 == 21);
            default: begin
                raw = m_s[m_w-1];
                m_s = {m_s[18:0], m_s[m_w-1] ^ m_s[m_t-1]};
                if (m_code == 4'd8) begin
                    b = raw | (m_z == 13);
                    m_z = b ? 0 : m_z + 1;
                end else begin
                    b = raw;
                end
            end
        endcase
        m_idx++;
    endtask

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic en, input logic rs, input logic ei, input logic [3:0] sel);
        bit_en = en; restart = rs; err_inject = ei; pat_sel = sel;
        @(posedge clk);
        @(negedge clk);
    endtask

    logic cap [0:4095];
    int g_ones, g_maxz;

    task automatic run_pat(input logic [3:0] code, input int n, input string req);
        logic e;
        int run;
        cyc(1'b0, 1'b1, 1'b0, code);
        chk(tx_valid == 1'b0, "R12", int'(tx_valid), 0);
        m_init(code);
        g_ones = 0; g_maxz = 0; run = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0, code);
            m_next(e);
            if (!(tx_valid === 1'b1 && tx_bit === e))
                chk(1'b0, req, int'({tx_valid, tx_bit}), int'({1'b1, e}));
            if (i < 4096) cap[i] = tx_bit;
            if (tx_bit) begin g_ones++; run = 0; end
            else begin run++; if (run > g_maxz) g_maxz = run; end
        end
        chk(1'b1, req, 0, 0);
        cyc(1'b0, 1'b0, 1'b0, code);
    endtask

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R4";
        endcase
    endfunction

    localparam int NV = 9;
    localparam logic [3:0] V_CODE [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};
    localparam int         V_LEN  [NV] = '{16, 16, 16, 32, 48, 96, 1022, 4094, 100000};

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic e;
        bit same;
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b0, "R1", int'(tx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: requests before any restart are ignored
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd1);
            chk(tx_valid == 1'b0, "R1", int'(tx_valid), 0);
        end

        // table walk over every used pattern code
        for (int v = 0; v < NV; v++) begin
            run_pat(V_CODE[v], V_LEN[v], req_of(V_CODE[v]));
            case (V_CODE[v])
                4'd4: chk(g_maxz <= 4, "R5", g_maxz, 4);
                4'd5: chk(g_ones == 12, "R6", g_ones, 12);
                4'd6: begin
                    same = 1'b1;
                    g_ones = 0;
                    for (int i = 0; i < 511; i++) begin
                        if (cap[i] !== cap[i+511]) same = 1'b0;
                        if (cap[i]) g_ones++;
                    end
                    chk(same, "R7", int'(same), 1);
                    chk(g_ones == 256, "R7", g_ones, 256);
                end
                4'd7: begin
                    same = 1'b1;
                    g_ones = 0;
                    for (int i = 0; i < 2047; i++) begin
                        if (cap[i] !== cap[i+2047]) same = 1'b0;
                        if (cap[i]) g_ones++;
                    end
                    chk(same, "R8", int'(same), 1);
                    chk(g_ones == 1024, "R8", g_ones, 1024);
                    chk(g_maxz <= 10, "R13", g_maxz, 10);
                end
                4'd8: chk(g_maxz <= 13, "R9", g_maxz, 13);
                default: ;
            endcase
        end

        // R2: select changes without restart are ignored
        cyc(1'b0, 1'b1, 1'b0, 4'd1);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd0);
            chk(tx_valid && tx_bit, "R2", int'({tx_valid, tx_bit}), 3);
        end

        // R3: gaps pause the 1-in-8 sequence without skipping
        cyc(1'b0, 1'b1, 1'b0, 4'd3);
        m_init(4'd3);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd3);
            m_next(e);
            chk(tx_valid && tx_bit == e, "R3", int'({tx_valid, tx_bit}), int'({1'b1, e}));
            cyc(1'b0, 1'b0, 1'b0, 4'd3);
            chk(!tx_valid, "R3", int'(tx_valid), 0);
            cyc(1'b0, 1'b0, 1'b0, 4'd3);
        end

        // R11: error held over a pause, then error with a request
        cyc(1'b0, 1'b1, 1'b0, 4'd6);
        m_init(4'd6);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd6);
            m_next(e);
            chk(tx_bit == e, "R11", int'(tx_bit), int'(e));
        end
        cyc(1'b0, 1'b0, 1'b1, 4'd6);
        chk(!tx_valid, "R11", int'(tx_valid), 0);
        cyc(1'b1, 1'b0, 1'b0, 4'd6);
        m_next(e);
        chk(tx_valid && tx_bit == !e, "R11", int'(tx_bit), int'(!e));
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd6);
            m_next(e);
            chk(tx_bit == e, "R11", int'(tx_bit), int'(e));
        end
        cyc(1'b1, 1'b0, 1'b1, 4'd6);
        m_next(e);
        chk(tx_valid && tx_bit == !e, "R11", int'(tx_bit), int'(!e));
        cyc(1'b1, 1'b0, 1'b0, 4'd6);
        m_next(e);
        chk(tx_bit == e, "R11", int'(tx_bit), int'(e));

        // R12: restart drops a pending error and restarts the sequence
        cyc(1'b0, 1'b0, 1'b1, 4'd6);
        cyc(1'b0, 1'b1, 1'b0, 4'd6);
        chk(!tx_valid, "R12", int'(tx_valid), 0);
        m_init(4'd6);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd6);
            m_next(e);
            chk(tx_valid && tx_bit == e, "R12", int'(tx_bit), int'(e));
        end

        // R10: unused code leaves the block silent
        cyc(1'b0, 1'b1, 1'b0, 4'd12);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 4'd1);
            chk(!tx_valid, "R10", int'(tx_valid), 0);
        end

        cyc(1'b0, 1'b0, 1'b0, 4'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule